// File: doc/BRIEF.md
# Warp Load Line Coalescer

This block sits between the address stage of a wide SIMD core and the first-level data cache. It takes in one load instruction per accepted transfer. That instruction carries a warp identifier, a 32-bit active-thread mask, and one 32-bit byte address for each of the 32 threads. The block sorts those addresses into 128-byte cache lines. It then sends out at most one line request per cycle. Each request is tagged with the warp identifier and a 32-bit map of the threads that the line serves.

A load whose active threads all land in one line drains in a single request. A divergent load stays in the block and sends one request per cycle until every distinct line has gone out. Incoming instructions wait in a small queue ahead of the grouping stage, so a producer can keep issuing while a divergent load drains.

Both data sides use valid/ready handshakes:
- An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A request is taken on a rising edge where `out_valid` and `out_ready` are both high.
- `in_ready` depends only on how full the queue is.
- When `out_ready` is low, the pending request is held unchanged.

Top module: `warp_line_coalescer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Active threads whose addresses share bits [31:7] (the same 128-byte line) are served by one request, and `out_line` equals address bits [31:7].
- R3: Each request is for the line of the lowest-numbered active thread not yet served. Bit i of `out_map` is set exactly for the not-yet-served active threads whose address lies in that line.
- R4: At most one request is handed off per cycle. A load touching K distinct lines produces exactly K requests, and with `out_ready` held high they appear on K consecutive cycles.
- R5: Threads whose mask bit is 0 never appear in any map. An instruction with an all-zero mask produces no request.
- R6: Every request of an instruction carries that instruction's warp identifier on `out_warp`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_line`, `out_warp` and `out_map` stay unchanged in the next cycle.
- R8: With the output stalled, the block accepts the instruction being grouped plus QDEPTH queued ones (5 with defaults). After that, `in_ready` stays low until something leaves the queue.
- R9: Instructions are served in arrival order. The first request of the next instruction is valid in the cycle right after the last request of the previous one is handed off.
- R10: Suppose an instruction is accepted at rising edge k while the block is idle and the queue is empty. Then `out_valid` is low after edge k and high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Queue has room |
| in_warp | input | 6 | Warp identifier of the offered instruction |
| in_mask | input | 32 | Active-thread mask, bit i for thread i |
| in_addrs | input | 1024 | Byte addresses, thread i in bits [32i+31:32i] |
| out_valid | output | 1 | Line request present |
| out_ready | input | 1 | Consumer takes the request |
| out_line | output | 25 | Line address (byte address bits [31:7]) |
| out_warp | output | 6 | Warp identifier of the request |
| out_map | output | 32 | Threads served by this line |

## Verification
Timing of the results:
- An instruction pushed into an empty, idle block passes through two registers, the queue entry and the grouping state. Its first request is therefore due after the second rising edge (R10), and the bench samples at the falling edge after each of those two edges.
- The request shown at a falling edge is consumed at the next rising edge. The following request, which may belong to the next queued instruction, is due at the falling edge after that.

How the bench samples:
- Every output is read only at falling edges.
- Inputs are changed only at falling edges.
- The collection routine treats a missing `out_valid` between the first and last expected request as a gap failure.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int N_THR      = 32;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 128;
  localparam int LINE_SH    = $clog2(LINE_BYTES);
  localparam int LINE_W     = ADDR_W - LINE_SH;
  localparam int WARP_W     = 6;
  localparam int ADDRS_W    = N_THR * ADDR_W;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [N_THR-1:0]   tmask_t;
  typedef logic [WARP_W-1:0]  warp_t;
  typedef logic [ADDRS_W-1:0] addrs_t;

  typedef struct packed {
    warp_t  warp;
    tmask_t mask;
    addrs_t addrs;
  } instr_t;

  function automatic line_t line_of(addr_t a);
    return a[ADDR_W-1:LINE_SH];
  endfunction
endpackage

// File: rtl/coal_queue.sv
module coal_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/coal_pick.sv
module coal_pick
  import coal_pkg::*;
(
  input  tmask_t pend,
  input  addrs_t addrs,
  output line_t  sel_line,
  output tmask_t sel_map
);
  line_t lines [N_THR];

  for (genvar i = 0; i < N_THR; i++) begin : g_line
    assign lines[i] = line_of(addrs[i*ADDR_W +: ADDR_W]);
  end

  // lowest pending thread wins: scan downward so the last hit is the lowest
  always_comb begin
    sel_line = '0;
    for (int i = N_THR - 1; i >= 0; i--) begin
      if (pend[i]) sel_line = lines[i];
    end
  end

  for (genvar i = 0; i < N_THR; i++) begin : g_match
    assign sel_map[i] = pend[i] && (lines[i] == sel_line);
  end
endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer
  import coal_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WARP_W-1:0]       in_warp,
  input  logic [N_THR-1:0]        in_mask,
  input  logic [N_THR*ADDR_W-1:0] in_addrs,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LINE_W-1:0]       out_line,
  output logic [WARP_W-1:0]       out_warp,
  output logic [N_THR-1:0]        out_map
);
  localparam int IW = $bits(instr_t);

  instr_t q_in, q_out;
  logic   q_full, q_empty, q_push, q_pop;

  tmask_t pend_q;
  warp_t  warp_q;
  addrs_t addr_q;

  line_t  pick_line;
  tmask_t pick_map, remain;
  logic   fire, last;

  assign q_in   = '{warp: in_warp, mask: in_mask, addrs: in_addrs};
  assign in_ready = !q_full;
  assign q_push = in_valid && !q_full;

  coal_queue #(.W(IW), .DEPTH(QDEPTH)) i_q (
    .clk  (clk),
    .rst_n(rst_n),
    .push (q_push),
    .din  (q_in),
    .full (q_full),
    .pop  (q_pop),
    .dout (q_out),
    .empty(q_empty)
  );

  coal_pick i_pick (
    .pend    (pend_q),
    .addrs   (addr_q),
    .sel_line(pick_line),
    .sel_map (pick_map)
  );

  assign out_valid = |pend_q;
  assign fire      = out_valid && out_ready;
  assign remain    = pend_q & ~pick_map;
  assign last      = (remain == '0);
  // a new instruction enters when idle or as the last line of the current one leaves
  assign q_pop     = !q_empty && (!out_valid || (fire && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      warp_q <= '0;
    end else if (q_pop) begin
      pend_q <= q_out.mask;
      warp_q <= q_out.warp;
    end else if (fire) begin
      pend_q <= remain;
    end
  end

  always_ff @(posedge clk) begin
    if (q_pop) addr_q <= q_out.addrs;
  end

  assign out_line = pick_line;
  assign out_warp = warp_q;
  assign out_map  = pick_map;
endmodule

// File: rtl/coal_chk.sv
module coal_chk
  import coal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LINE_W-1:0] out_line,
  input logic [WARP_W-1:0] out_warp,
  input logic [N_THR-1:0]  out_map,
  input logic [N_THR-1:0]  pend,
  input logic              q_pop
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line)
                                   && $stable(out_warp) && $stable(out_map)));

  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_map & ~pend) == '0)
                   && ((pend & (~pend + 1'b1) & out_map) != '0)));

  p_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_map != pend))
      |=> (pend == ($past(pend) & ~$past(out_map))));

  p_warp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_map != pend)) |=> (out_warp == $past(out_warp)));

  p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !q_pop) |=> !in_ready);

  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && out_valid) |-> out_ready);
endmodule

bind warp_line_coalescer coal_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_line (out_line),
  .out_warp (out_warp),
  .out_map  (out_map),
  .pend     (pend_q),
  .q_pop    (q_pop)
);

// File: tb/test_warp_line_coalescer.sv
module test_warp_line_coalescer;
  import coal_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [WARP_W-1:0] in_warp = '0;
  logic [N_THR-1:0] in_mask = '0;
  logic [N_THR*ADDR_W-1:0] in_addrs = '0;
  logic out_valid, out_ready = 1'b0;
  logic [LINE_W-1:0] out_line;
  logic [WARP_W-1:0] out_warp;
  logic [N_THR-1:0] out_map;

  always #2 clk = ~clk;

  warp_line_coalescer i_warp_line_coalescer (
    .clk, .rst_n, .in_valid, .in_ready, .in_warp, .in_mask, .in_addrs,
    .out_valid, .out_ready, .out_line, .out_warp, .out_map
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] ta [N_THR];
  logic [63:0] exp_line [128];
  logic [63:0] exp_map [128];
  logic [63:0] exp_warp [128];
  int exp_n = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  // expected requests from R2/R3/R5: lowest pending active thread picks the line
  task automatic model(int warp, logic [31:0] mask);
    logic [31:0] p = mask;
    while (p != 0) begin
      int lo = 0;
      logic [31:0] m = 0;
      for (int i = N_THR - 1; i >= 0; i--) if (p[i]) lo = i;
      for (int j = 0; j < N_THR; j++)
        if (p[j] && (ta[j] >> 7) == (ta[lo] >> 7)) m[j] = 1'b1;
      exp_line[exp_n] = 64'(ta[lo] >> 7);
      exp_map[exp_n]  = 64'(m);
      exp_warp[exp_n] = 64'(warp);
      exp_n++;
      p &= ~m;
    end
  endtask

  // drive at a falling edge; returns at the next falling edge
  task automatic push(int warp, logic [31:0] mask, output bit acc);
    in_valid = 1'b1;
    in_warp  = WARP_W'(warp);
    in_mask  = mask;
    for (int i = 0; i < N_THR; i++) in_addrs[i*ADDR_W +: ADDR_W] = ta[i];
    acc = in_ready;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(string req);
    int idx = 0;
    int guard = 0;
    out_ready = 1'b1;
    while (idx < exp_n && guard < 300) begin
      if (out_valid) begin
        check({req, " line"}, 64'(out_line), exp_line[idx]);
        check({req, " map"},  64'(out_map),  exp_map[idx]);
        check({req, " warp"}, 64'(out_warp), exp_warp[idx]);
        idx++;
      end else if (idx > 0) begin
        check({req, " R4 gap"}, 64'(out_valid), 64'd1);
      end
      @(negedge clk);
      guard++;
    end
    check({req, " count"}, 64'(idx), 64'(exp_n));
    out_ready = 1'b0;
    check({req, " drained"}, 64'(out_valid), 64'd0);
    exp_n = 0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_converged();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'h1000 + 32'(i * 4);
    model(5, 32'hFFFF_FFFF);
    push(5, 32'hFFFF_FFFF, acc);
    check("R10 accept", 64'(acc), 64'd1);
    check("R10 low after edge k", 64'(out_valid), 64'd0);
    @(negedge clk);
    check("R10 high after edge k+1", 64'(out_valid), 64'd1);
    check("R2 one line", 64'(exp_n), 64'd1);
    collect("R2 R6 converged");
  endtask

  task automatic t_diverge_up();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'(i * 128 + (i % 5));
    model(7, 32'hFFFF_FFFF);
    push(7, 32'hFFFF_FFFF, acc);
    collect("R4 divergent ascending");
  endtask

  task automatic t_diverge_down();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'((31 - i) * 128 + 32'h4000);
    model(12, 32'hFFFF_FFFF);
    push(12, 32'hFFFF_FFFF, acc);
    collect("R3 divergent descending");
  endtask

  task automatic t_mixed();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'h8000 + 32'((i % 3) * 256 + i);
    model(33, 32'hF0F0_F0F0);
    push(33, 32'hF0F0_F0F0, acc);
    collect("R3 R5 mixed partial mask");
  endtask

  task automatic t_boundary();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'h0;
    ta[0] = 127; ta[1] = 128; ta[2] = 0; ta[3] = 255;
    exp_line[0] = 64'd0; exp_map[0] = 64'h5; exp_warp[0] = 64'd2;
    exp_line[1] = 64'd1; exp_map[1] = 64'hA; exp_warp[1] = 64'd2;
    exp_n = 2;
    push(2, 32'h0000_000F, acc);
    collect("R2 line boundary");
  endtask

  task automatic t_zero_mask();
    bit acc;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'(i * 128);
    push(9, 32'h0, acc);
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check("R5 zero mask silent", 64'(out_valid), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    model(10, 32'h0000_0100);
    push(10, 32'h0000_0100, acc);
    collect("R5 after zero mask");
  endtask

  task automatic t_stall();
    bit acc;
    logic [LINE_W-1:0] l0;
    logic [N_THR-1:0] m0;
    for (int i = 0; i < N_THR; i++) ta[i] = 32'h2_0000 + 32'((i % 4) * 128);
    model(21, 32'hFFFF_FFFF);
    push(21, 32'hFFFF_FFFF, acc);
    @(negedge clk);
    l0 = out_line;
    m0 = out_map;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 valid held", 64'(out_valid), 64'd1);
      check("R7 line held", 64'(out_line), 64'(l0));
      check("R7 map held", 64'(out_map), 64'(m0));
    end
    collect("R7 after stall");
  endtask

  task automatic t_queue();
    int taken = 0;
    bit acc;
    for (int w = 1; w <= 7; w++) begin
      for (int i = 0; i < N_THR; i++) ta[i] = 32'(w * 1024 + i);
      push(w, 32'hFFFF_FFFF, acc);
      if (acc) begin
        taken++;
        model(w, 32'hFFFF_FFFF);
      end
    end
    check("R8 accepted while stalled", 64'(taken), 64'd5);
    check("R8 in_ready low", 64'(in_ready), 64'd0);
    collect("R9 queued order back to back");
    check("R8 in_ready back", 64'(in_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_converged();
    t_diverge_up();
    t_diverge_down();
    t_mixed();
    t_boundary();
    t_zero_mask();
    t_stall();
    t_queue();
    summary();
  end
endmodule